// File: doc/BRIEF.md
# Contrast PWM Generator

This block drives one pulse-width modulated pin for display contrast or backlight brightness. Software programs two registers through write strobes that share one data bus. The first register is an 8-bit duty value. The second is a control word with three fields: a prescaler select, an output polarity bit and an enable bit.

When the block is enabled, the system clock is divided by the selected power of two. Each divided tick advances an 8-bit period counter, and the pin is active while that counter is below the duty value in use. A newly written duty value takes effect only when the counter wraps, so a period is never cut short or stretched. While the block is disabled, both counters are held at zero and the pin sits at the inactive level of the current polarity.

Top module: `contrast_pwm`

## Requirements
- R1: After reset, the duty register holds 0xC8 and the control word is zero (disabled, polarity 0), so the pin is high. Enabling without writing a duty value gives 200 active cycles in every 256-tick period.
- R2: Control word bits [1:0] select a divide ratio of 1, 2, 4 or 8 for codes 0, 1, 2 and 3. One period lasts 256 × ratio clock cycles.
- R3: While enabled, the pin is active while the period counter is below the duty value in use. This gives duty × ratio active cycles per period.
- R4: Control word bit 2 sets polarity. When it is 1, the active level is high. When it is 0, the output is inverted and the active level is low.
- R5: Control word bit 3 is the enable. While it is 0, the pin holds the inactive level (the inverse of bit 2) and the prescaler and period counter are held at zero.
- R6: A duty value of 0 keeps the pin at the inactive level for the whole time the block is enabled.
- R7: A duty value written while the block is enabled takes effect only at the next counter wraparound. The period in progress keeps its old active length. While the block is disabled, the written value is taken at once.
- R8: Both registers update on the clock edge that samples their write strobe, and the pin is registered. After a write that enables the block, the pin shows the inactive level after the first edge and the active level after the second edge (for a non-zero duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrDuty | input | 1 | Write strobe for the duty register |
| wrCtrl | input | 1 | Write strobe for the control word |
| wrData | input | 8 | Write data shared by both registers |
| pwmOut | output | 1 | PWM pin |

## Verification
Timing of results relative to a strobe sampled at an edge:

- **Register writes:** a register write is visible inside the block after that edge.
- **Pin:** the pin reflects the new state one edge later. The R8 check samples at the two falling edges that follow the strobe for this reason.
- **Divide ratio and duty:** these show up as active cycles counted over exactly one full period of 256 × ratio cycles, taken once the block is enabled and settled.
- **Deferred duty (R7):** the window starts at a rising edge of the pin, which is the start of a period.

On every falling edge, a behavioural model in the bench that advances on the rising edge is compared with the pin. A one-cycle slip in any path is therefore caught.

// File: rtl/contrast_pwm_pkg.sv
package contrast_pwm_pkg;

  // Strobes passed from the control section to the datapath each cycle
  typedef struct packed {
    logic enable;    // block enabled
    logic polarity;  // 1: active high, 0: active low
    logic tick;      // divided clock tick: advance the period counter
    logic loadDuty;  // copy the written duty into the live duty
  } pwmStrobe_t;

endpackage

// File: rtl/contrast_pwm_ctrl.sv
module contrast_pwm_ctrl
  import contrast_pwm_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic [SEL_W+1:0] ctrlData,
  input  logic             atTop,
  output pwmStrobe_t       strobe,
  output logic [SEL_W-1:0] prescaleSel
);

  localparam int PRE_W   = (1 << SEL_W) - 1;
  localparam int POL_BIT = SEL_W;
  localparam int EN_BIT  = SEL_W + 1;

  logic [SEL_W-1:0] selReg;
  logic             polReg;
  logic             enReg;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMask;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      polReg <= 1'b0;
      enReg  <= 1'b0;
    end else if (wrCtrl) begin
      selReg <= ctrlData[SEL_W-1:0];
      polReg <= ctrlData[POL_BIT];
      enReg  <= ctrlData[EN_BIT];
    end
  end

  // Mask of low prescaler bits that must all be one for a tick
  for (genvar i = 0; i < PRE_W; i++) begin : gMask
    assign divMask[i] = (i < int'(selReg));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (enReg) preCnt <= preCnt + 1'b1;
    else            preCnt <= '0;
  end

  assign tick = enReg && ((preCnt & divMask) == divMask);

  always_comb begin
    strobe.enable   = enReg;
    strobe.polarity = polReg;
    strobe.tick     = tick;
    strobe.loadDuty = !enReg || (tick && atTop);
  end

  assign prescaleSel = selReg;

endmodule

// File: rtl/contrast_pwm_dp.sv
module contrast_pwm_dp
  import contrast_pwm_pkg::*;
#(
  parameter int              DUTY_W    = 8,
  parameter logic [DUTY_W-1:0] DUTY_INIT = 8'hC8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrDuty,
  input  logic [DUTY_W-1:0] dutyData,
  input  pwmStrobe_t        strobe,
  output logic              atTop,
  output logic [DUTY_W-1:0] periodCnt,
  output logic [DUTY_W-1:0] liveDuty,
  output logic              pinOut
);

  logic [DUTY_W-1:0] dutyReg;
  logic              active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dutyReg <= DUTY_INIT;
    else if (wrDuty) dutyReg <= dutyData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                liveDuty <= DUTY_INIT;
    else if (strobe.loadDuty) liveDuty <= dutyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              periodCnt <= '0;
    else if (!strobe.enable) periodCnt <= '0;
    else if (strobe.tick)   periodCnt <= periodCnt + 1'b1;
  end

  assign atTop  = &periodCnt;
  assign active = strobe.enable && (periodCnt < liveDuty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinOut <= 1'b1;
    else       pinOut <= strobe.polarity ? active : !active;
  end

endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
  import contrast_pwm_pkg::*;
#(
  parameter int                DUTY_W    = 8,
  parameter int                SEL_W     = 2,
  parameter logic [DUTY_W-1:0] DUTY_INIT = 8'hC8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrDuty,
  input  logic              wrCtrl,
  input  logic [DUTY_W-1:0] wrData,
  output logic              pwmOut
);

  localparam int CTRL_W = SEL_W + 2;

  pwmStrobe_t        strobe;
  logic              atTop;
  logic [SEL_W-1:0]  prescaleSel;
  logic [DUTY_W-1:0] periodCnt;
  logic [DUTY_W-1:0] liveDuty;

  contrast_pwm_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrCtrl     (wrCtrl),
    .ctrlData   (wrData[CTRL_W-1:0]),
    .atTop      (atTop),
    .strobe     (strobe),
    .prescaleSel(prescaleSel)
  );

  contrast_pwm_dp #(.DUTY_W(DUTY_W), .DUTY_INIT(DUTY_INIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrDuty   (wrDuty),
    .dutyData (wrData),
    .strobe   (strobe),
    .atTop    (atTop),
    .periodCnt(periodCnt),
    .liveDuty (liveDuty),
    .pinOut   (pwmOut)
  );

endmodule

// File: rtl/contrast_pwm_chk.sv
module contrast_pwm_chk
  import contrast_pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input pwmStrobe_t        strobe,
  input logic [SEL_W-1:0]  prescaleSel,
  input logic [DUTY_W-1:0] periodCnt,
  input logic [DUTY_W-1:0] liveDuty,
  input logic              pwmOut
);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |=> (pwmOut == !$past(strobe.polarity)));

  assert_counter_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |=> (periodCnt == '0));

  assert_zero_duty_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enable && liveDuty == '0) |=> (pwmOut == !$past(strobe.polarity)));

  assert_active_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enable && periodCnt < liveDuty) |=> (pwmOut == $past(strobe.polarity)));

  assert_duty_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enable && !strobe.loadDuty) |=> $stable(liveDuty));

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && prescaleSel != '0 && strobe.enable) |=> !strobe.tick);

endmodule

bind contrast_pwm contrast_pwm_chk #(.DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strobe     (strobe),
  .prescaleSel(prescaleSel),
  .periodCnt  (periodCnt),
  .liveDuty   (liveDuty),
  .pwmOut     (pwmOut)
);

// File: tb/sim_contrast_pwm.sv
`timescale 1ns/1ps
module sim_contrast_pwm;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrDuty = 1'b0;
  logic       wrCtrl = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mSel = 0, mPol = 0, mEn = 0, mDuty = 200, mLive = 200, mSub = 0, mCnt = 0;
  int mDiv;
  bit mTick, mAct;
  bit mOut = 1'b1;

  always #10 clk = ~clk;

  contrast_pwm u0 (
    .clk(clk), .rstN(rstN), .wrDuty(wrDuty), .wrCtrl(wrCtrl),
    .wrData(wrData), .pwmOut(pwmOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mSel = 0; mPol = 0; mEn = 0; mDuty = 200; mLive = 200;
      mSub = 0; mCnt = 0; mOut = 1'b1;
    end else begin
      mDiv  = 1 << mSel;
      mAct  = (mEn != 0) && (mCnt < mLive);
      mOut  = (mPol != 0) ? mAct : !mAct;
      mTick = (mEn != 0) && ((mSub % mDiv) == mDiv - 1);
      if (mEn == 0 || (mTick && mCnt == 255)) mLive = mDuty;
      if (mEn == 0) mCnt = 0;
      else if (mTick) mCnt = (mCnt + 1) % 256;
      mSub = (mEn != 0) ? (mSub + 1) % 8 : 0;
      if (wrDuty) mDuty = int'(wrData);
      if (wrCtrl) begin
        mSel = int'(wrData[1:0]);
        mPol = int'(wrData[2]);
        mEn  = int'(wrData[3]);
      end
    end
  end

  // cycle-by-cycle comparison against the model (R3 R4 R5 R7)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (pwmOut !== mOut) begin
        errors++;
        $display("FAIL model R3 cycle %0d: actual %0b expected %0b", cyc, pwmOut, mOut);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeDuty(int v);
    @(negedge clk); wrDuty = 1'b1; wrData = 8'(v);
    @(negedge clk); wrDuty = 1'b0;
  endtask

  task automatic writeCtrl(int en, int pol, int sel);
    @(negedge clk); wrCtrl = 1'b1; wrData = 8'((en << 3) | (pol << 2) | sel);
    @(negedge clk); wrCtrl = 1'b0;
  endtask

  task automatic countHigh(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) h++;
    end
  endtask

  task automatic runWindow(string req, int duty, int pol, int sel, int expHigh);
    int h;
    writeCtrl(0, pol, sel);
    if (duty >= 0) writeDuty(duty);
    writeCtrl(1, pol, sel);
    repeat (4) @(negedge clk);
    countHigh(256 << sel, h);
    expect_eq(req, h, expHigh);
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    expect_eq("R1 pin during reset", int'(pwmOut), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expect_eq("R1 pin after reset", int'(pwmOut), 1);

    // R1: reset duty 0xC8 used directly
    runWindow("R1 default duty high count", -1, 1, 0, 200);
    // R2 and R3: ratios and duty values
    runWindow("R2 R3 divide by 2 duty 0x40", 8'h40, 1, 1, 128);
    runWindow("R2 R3 divide by 4 duty 0x80", 8'h80, 1, 2, 512);
    runWindow("R2 R3 divide by 8 duty 0xFF", 8'hFF, 1, 3, 2040);
    runWindow("R3 divide by 1 duty 0x01", 8'h01, 1, 0, 1);
    // R4: inverted polarity, active low for 64 of 256
    runWindow("R4 inverted polarity", 8'h40, 0, 0, 192);
    // R6: zero duty
    runWindow("R6 zero duty active high", 8'h00, 1, 0, 0);
    runWindow("R6 zero duty active low", 8'h00, 0, 1, 512);

    // R5: disabled holds inactive level
    writeCtrl(0, 1, 0);
    repeat (2) @(negedge clk);
    countHigh(40, h);
    expect_eq("R5 disabled polarity 1 stays low", h, 0);
    writeCtrl(0, 0, 2);
    repeat (2) @(negedge clk);
    countHigh(40, h);
    expect_eq("R5 disabled polarity 0 stays high", h, 40);

    // R8: enable timing
    writeCtrl(0, 1, 0);
    writeDuty(8'h80);
    repeat (3) @(negedge clk);
    writeCtrl(1, 1, 0);
    expect_eq("R8 pin after first edge", int'(pwmOut), 0);
    @(negedge clk);
    expect_eq("R8 pin after second edge", int'(pwmOut), 1);

    // R7: duty change mid period is deferred to the wrap
    writeCtrl(0, 1, 0);
    writeDuty(8'h20);
    writeCtrl(1, 1, 0);
    @(negedge clk);
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
    // first sample of the period has been seen (high)
    fork
      begin
        repeat (8) @(negedge clk);
        wrDuty = 1'b1; wrData = 8'hA0;
        @(negedge clk); wrDuty = 1'b0;
      end
      countHigh(255, h);
    join
    expect_eq("R7 period in progress keeps old duty", h + 1, 32);
    countHigh(256, h);
    expect_eq("R7 next period uses new duty", h, 160);

    writeCtrl(0, 1, 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule